// File: doc/BRIEF.md
# Serial NOR Flash Responder

This block is a synthesizable stand-in for a small serial NOR flash. It sits on the far side of an SPI link in mode 0 and answers a flash master controller the way a real device would. A local clock oversamples the serial clock, chip select and data-in pins, so the whole block lives in one clock domain. Each transfer opens with an opcode byte. The opcode picks a sequence of further phases: address bytes, a dummy byte, a stream of returned bytes, or a stream of bytes to program.

A status register holds a write-enable latch in bit 1. Status writes, page programming and both erase commands only take effect while this latch is set. The latch drops when chip select rises after one of those commands has executed. The storage array is a register file that stands in for one 64 KB sector. Reads and programs use the low address bits. Sector erase acts only when the high address byte names the modelled sector. A power-down command makes the block deaf to everything except the signature read, and that read also wakes it.

Top module: `sfr_flash_slave`

## Requirements
- R1: After reset, MISO is high, status reads 0x00 and every array byte reads 0xFF.
- R2: Bits travel MSB first. MOSI is taken on rising SCLK and MISO changes only on falling SCLK. The first bit of a returned byte appears on the falling edge that ends the previous byte.
- R3: Opcode 0x06 sets status bit 1 (write-enable latch) and opcode 0x04 clears it.
- R4: With the latch clear, opcodes 0x01 (status write), 0x02 (program), 0xD8 (sector erase) and 0xC7 (bulk erase) change neither status nor array.
- R5: The latch clears when chip select rises after an executed status write, program, sector erase or bulk erase.
- R6: Opcode 0x03 takes three address bytes, high byte first, and then returns array bytes from that address, incrementing without limit while SCLK runs. The array index is the low log2(MEM_BYTES) address bits.
- R7: Opcode 0x0B is the same as 0x03, except that one dummy byte (MISO high) comes between the address and the first data byte.
- R8: Opcode 0x02 takes three address bytes and then data bytes. Each data byte is ANDed into the stored byte, and the low address byte wraps within its 256-byte page.
- R9: Opcode 0xD8 sets every array byte to 0xFF when address bits 23:16 equal SECTOR_ID, and otherwise leaves the array alone. Opcode 0xC7 always sets every byte to 0xFF.
- R10: Opcode 0x01 followed by one byte loads status bits 7:2 from that byte. Bit 1 stays the latch and bit 0 reads 0.
- R11: Opcode 0xAB followed by three dummy bytes returns 0x13 on every later byte of the transfer.
- R12: After opcode 0xB9 every opcode except 0xAB is ignored and MISO stays high. Opcode 0xAB wakes the block.
- R13: Chip select rising aborts any phase and discards a partial byte. This holds even when the rise arrives in the same sampled cycle as the eighth SCLK rise. The next transfer starts at the opcode phase.
- R14: MISO is high while chip select is high and during every byte that carries no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |

## Verification
Chip select can rise in the same sampled cycle as the SCLK rise that would complete a byte. In that cycle, abort and byte execution compete. The bench provokes this by driving SCLK high and chip select high at the same instant on the last bit of a write-enable opcode. A following status read must show the latch still clear, which proves that deselection won and the byte was dropped.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_STREAM, PH_WRSR, PH_PROG, PH_DONE
  } phase_e;

  typedef enum logic [2:0] {
    K_NONE, K_READ, K_FAST, K_PROG, K_SERASE, K_SIG, K_STAT
  } kind_e;

  localparam logic [7:0] OP_WR_EN      = 8'h06;
  localparam logic [7:0] OP_WR_DIS     = 8'h04;
  localparam logic [7:0] OP_RD_STAT    = 8'h05;
  localparam logic [7:0] OP_WR_STAT    = 8'h01;
  localparam logic [7:0] OP_READ       = 8'h03;
  localparam logic [7:0] OP_READ_FAST  = 8'h0B;
  localparam logic [7:0] OP_PROGRAM    = 8'h02;
  localparam logic [7:0] OP_SECT_ERASE = 8'hD8;
  localparam logic [7:0] OP_CHIP_ERASE = 8'hC7;
  localparam logic [7:0] OP_SLEEP      = 8'hB9;
  localparam logic [7:0] OP_WAKE_ID    = 8'hAB;
  localparam logic [7:0] ID_BYTE       = 8'h13;
endpackage

// File: rtl/sfr_pin_sync.sv
module sfr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic srst_n,
  output logic cs_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s
);
  logic [1:0]        rst_pipe;
  logic [STAGES-1:0] sclk_p, cs_p, mosi_p;
  logic              sclk_d;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[STAGES-2:0], sclk};
      cs_p   <= {cs_p[STAGES-2:0], cs_n};
      mosi_p <= {mosi_p[STAGES-2:0], mosi};
      sclk_d <= sclk_p[STAGES-1];
    end
  end

  assign cs_act    = ~cs_p[STAGES-1];
  assign mosi_s    = mosi_p[STAGES-1];
  assign sclk_rise = cs_act &  sclk_p[STAGES-1] & ~sclk_d;
  assign sclk_fall = cs_act & ~sclk_p[STAGES-1] &  sclk_d;
endmodule

// File: rtl/sfr_tx_shifter.sv
module sfr_tx_shifter
  import sfr_pkg::*;
(
  input  logic              clk,
  input  logic              srst_n,
  input  logic              cs_act,
  input  logic              sclk_fall,
  input  logic              byte_start,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              miso
);
  logic [BYTE_W-1:0] sr_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      miso <= 1'b1;
      sr_q <= '1;
    end else if (!cs_act) begin
      miso <= 1'b1;
      sr_q <= '1;
    end else if (sclk_fall) begin
      if (byte_start) begin
        miso <= load_byte[BYTE_W-1];
        sr_q <= {load_byte[BYTE_W-2:0], 1'b1};
      end else begin
        miso <= sr_q[BYTE_W-1];
        sr_q <= {sr_q[BYTE_W-2:0], 1'b1};
      end
    end
  end
endmodule

// File: rtl/sfr_mem_array.sv
module sfr_mem_array
  import sfr_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              erase
);
  logic [BYTE_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)  mem_q[g] <= '1;
      else if (erase) mem_q[g] <= '1;
      else if (hit)   mem_q[g] <= mem_q[g] & wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/sfr_flash_slave.sv
module sfr_flash_slave
  import sfr_pkg::*;
#(
  parameter int          MEM_BYTES   = 512,
  parameter logic [7:0]  SECTOR_ID   = 8'h00,
  parameter int          SYNC_STAGES = 2,
  localparam int         AW          = $clog2(MEM_BYTES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  logic srst_n, cs_act, sclk_rise, sclk_fall, mosi_s;

  phase_e      phase_q, phase_d;
  kind_e       kind_q, kind_d;
  logic [2:0]  bit_cnt_q, bit_cnt_d;
  logic [6:0]  shreg_q, shreg_d;
  logic [1:0]  cnt_q, cnt_d;
  logic [23:0] addr_q, addr_d;
  logic [7:0]  resp_q, resp_d;
  logic        wel_q, wel_d;
  logic [5:0]  sr_hi_q, sr_hi_d;
  logic        consume_q, consume_d;
  logic        sleep_q, sleep_d;

  logic        byte_done;
  logic [7:0]  rx_byte, status;
  logic [23:0] new_addr;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0]  mem_rd;
  logic        mem_wr, mem_erase;

  sfr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .srst_n(srst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .mosi_s(mosi_s)
  );

  sfr_mem_array #(.DEPTH(MEM_BYTES)) u_mem (
    .clk(clk), .srst_n(srst_n), .rd_addr(mem_rd_addr), .rd_data(mem_rd),
    .wr_en(mem_wr), .wr_addr(addr_q[AW-1:0]), .wr_data(rx_byte),
    .erase(mem_erase)
  );

  sfr_tx_shifter u_tx (
    .clk(clk), .srst_n(srst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
    .byte_start(bit_cnt_q == 3'd0), .load_byte(resp_q), .miso(miso)
  );

  assign byte_done   = sclk_rise && (bit_cnt_q == 3'd7);
  assign rx_byte     = {shreg_q, mosi_s};
  assign status      = {sr_hi_q, wel_q, 1'b0};
  assign new_addr    = {addr_q[15:0], rx_byte};
  assign mem_rd_addr = (phase_q == PH_ADDR && kind_q == K_READ) ?
                       new_addr[AW-1:0] : addr_q[AW-1:0];

  always_comb begin
    phase_d   = phase_q;
    kind_d    = kind_q;
    bit_cnt_d = bit_cnt_q;
    shreg_d   = shreg_q;
    cnt_d     = cnt_q;
    addr_d    = addr_q;
    resp_d    = resp_q;
    wel_d     = wel_q;
    sr_hi_d   = sr_hi_q;
    consume_d = consume_q;
    sleep_d   = sleep_q;
    mem_wr    = 1'b0;
    mem_erase = 1'b0;

    if (!cs_act) begin
      // deselect wins over any edge seen in the same cycle
      phase_d   = PH_OPC;
      kind_d    = K_NONE;
      bit_cnt_d = 3'd0;
      cnt_d     = 2'd0;
      resp_d    = 8'hFF;
      if (consume_q) begin
        wel_d     = 1'b0;
        consume_d = 1'b0;
      end
    end else if (sclk_rise) begin
      bit_cnt_d = bit_cnt_q + 3'd1;
      shreg_d   = {shreg_q[5:0], mosi_s};
      if (byte_done) begin
        resp_d = 8'hFF;
        unique case (phase_q)
          PH_OPC: begin
            cnt_d   = 2'd0;
            phase_d = PH_DONE;
            if (!sleep_q || rx_byte == OP_WAKE_ID) begin
              case (rx_byte)
                OP_WR_EN:   wel_d = 1'b1;
                OP_WR_DIS:  wel_d = 1'b0;
                OP_RD_STAT: begin
                  resp_d  = status;
                  kind_d  = K_STAT;
                  phase_d = PH_STREAM;
                end
                OP_WR_STAT: if (wel_q) phase_d = PH_WRSR;
                OP_READ: begin
                  kind_d  = K_READ;
                  phase_d = PH_ADDR;
                end
                OP_READ_FAST: begin
                  kind_d  = K_FAST;
                  phase_d = PH_ADDR;
                end
                OP_PROGRAM: if (wel_q) begin
                  kind_d  = K_PROG;
                  phase_d = PH_ADDR;
                end
                OP_SECT_ERASE: if (wel_q) begin
                  kind_d  = K_SERASE;
                  phase_d = PH_ADDR;
                end
                OP_CHIP_ERASE: if (wel_q) begin
                  mem_erase = 1'b1;
                  consume_d = 1'b1;
                end
                OP_SLEEP: sleep_d = 1'b1;
                OP_WAKE_ID: begin
                  sleep_d = 1'b0;
                  kind_d  = K_SIG;
                  phase_d = PH_ADDR;
                end
                default: phase_d = PH_DONE;
              endcase
            end
          end
          PH_ADDR: begin
            addr_d = new_addr;
            cnt_d  = cnt_q + 2'd1;
            if (cnt_q == 2'd2) begin
              unique case (kind_q)
                K_READ: begin
                  resp_d  = mem_rd;
                  addr_d  = new_addr + 24'd1;
                  phase_d = PH_STREAM;
                end
                K_FAST: phase_d = PH_DUMMY;
                K_PROG: phase_d = PH_PROG;
                K_SERASE: begin
                  mem_erase = (new_addr[23:16] == SECTOR_ID);
                  consume_d = 1'b1;
                  phase_d   = PH_DONE;
                end
                K_SIG: begin
                  resp_d  = ID_BYTE;
                  phase_d = PH_STREAM;
                end
                default: phase_d = PH_DONE;
              endcase
            end
          end
          PH_DUMMY: begin
            resp_d  = mem_rd;
            addr_d  = addr_q + 24'd1;
            phase_d = PH_STREAM;
          end
          PH_STREAM: begin
            unique case (kind_q)
              K_STAT: resp_d = status;
              K_SIG:  resp_d = ID_BYTE;
              K_READ, K_FAST: begin
                resp_d = mem_rd;
                addr_d = addr_q + 24'd1;
              end
              default: resp_d = 8'hFF;
            endcase
          end
          PH_WRSR: begin
            sr_hi_d   = rx_byte[7:2];
            consume_d = 1'b1;
            phase_d   = PH_DONE;
          end
          PH_PROG: begin
            mem_wr    = 1'b1;
            addr_d    = {addr_q[23:8], addr_q[7:0] + 8'd1};
            consume_d = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q   <= PH_OPC;
      kind_q    <= K_NONE;
      bit_cnt_q <= 3'd0;
      shreg_q   <= 7'd0;
      cnt_q     <= 2'd0;
      addr_q    <= 24'd0;
      resp_q    <= 8'hFF;
      wel_q     <= 1'b0;
      sr_hi_q   <= 6'd0;
      consume_q <= 1'b0;
      sleep_q   <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      kind_q    <= kind_d;
      bit_cnt_q <= bit_cnt_d;
      shreg_q   <= shreg_d;
      cnt_q     <= cnt_d;
      addr_q    <= addr_d;
      resp_q    <= resp_d;
      wel_q     <= wel_d;
      sr_hi_q   <= sr_hi_d;
      consume_q <= consume_d;
      sleep_q   <= sleep_d;
    end
  end
endmodule

// File: rtl/sfr_flash_slave_chk.sv
module sfr_flash_slave_chk
  import sfr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       sclk_rise,
  input logic       sclk_fall,
  input logic       byte_done,
  input logic [7:0] rx_byte,
  input phase_e     phase_q,
  input logic [2:0] bit_cnt_q,
  input logic       wel_q,
  input logic       consume_q,
  input logic       sleep_q,
  input logic       miso
);
  a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sclk_rise, sclk_fall}));

  a_r3_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase_q == PH_OPC && !sleep_q && rx_byte == OP_WR_EN) |=> wel_q);

  a_r3_latch_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase_q == PH_OPC && !sleep_q && rx_byte == OP_WR_DIS) |=> !wel_q);

  a_r4_gated_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PROG || phase_q == PH_WRSR) |-> wel_q);

  a_r5_latch_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && consume_q) |=> !wel_q);

  a_r12_sleep_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase_q == PH_OPC && sleep_q && rx_byte != OP_WAKE_ID)
      |=> phase_q == PH_DONE);

  a_r13_abort_to_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (phase_q == PH_OPC && bit_cnt_q == 3'd0));

  a_r14_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> miso);
endmodule

bind sfr_flash_slave sfr_flash_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall), .byte_done(byte_done), .rx_byte(rx_byte),
  .phase_q(phase_q), .bit_cnt_q(bit_cnt_q), .wel_q(wel_q),
  .consume_q(consume_q), .sleep_q(sleep_q), .miso(miso)
);

// File: tb/tb_sfr_flash_slave.sv
module tb_sfr_flash_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;
  int   checks = 0;
  int   fails  = 0;
  localparam int HALF = 6;

  always #10 clk = ~clk;

  sfr_flash_slave dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_start();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic frame_end();
    tick(HALF);
    cs_n = 1'b1;
    tick(10);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      tick(HALF);
      sclk = 1'b1;
      rx[i] = miso;
      tick(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] r;
    xfer(a[23:16], r);
    xfer(a[15:8], r);
    xfer(a[7:0], r);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    frame_start();
    xfer(op, r);
    frame_end();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] r;
    frame_start();
    xfer(8'h05, r);
    xfer(8'hFF, s);
    frame_end();
  endtask

  task automatic rd_mem(input logic [23:0] a, output logic [7:0] d0, output logic [7:0] d1);
    logic [7:0] r;
    frame_start();
    xfer(8'h03, r);
    send_addr(a);
    xfer(8'hFF, d0);
    xfer(8'hFF, d1);
    frame_end();
  endtask

  task automatic prog(input logic [23:0] a, input logic [7:0] b0, input logic [7:0] b1, input int n);
    logic [7:0] r;
    frame_start();
    xfer(8'h02, r);
    send_addr(a);
    xfer(b0, r);
    if (n > 1) xfer(b1, r);
    frame_end();
  endtask

  task automatic wr_status(input logic [7:0] v);
    logic [7:0] r;
    frame_start();
    xfer(8'h01, r);
    xfer(v, r);
    frame_end();
  endtask

  task automatic sect_erase(input logic [23:0] a);
    logic [7:0] r;
    frame_start();
    xfer(8'hD8, r);
    send_addr(a);
    frame_end();
  endtask

  task automatic t_reset();
    logic [7:0] s, d0, d1;
    check("R1 miso after reset", {7'd0, miso}, 8'h01);
    rd_status(s);
    check("R1 status after reset", s, 8'h00);
    rd_mem(24'h000000, d0, d1);
    check("R1 array erased at reset", d0, 8'hFF);
    check("R14 miso high with cs high", {7'd0, miso}, 8'h01);
  endtask

  task automatic t_latch();
    logic [7:0] s;
    cmd1(8'h06);
    rd_status(s);
    check("R3 write enable sets bit1", s, 8'h02);
    cmd1(8'h04);
    rd_status(s);
    check("R3 write disable clears bit1", s, 8'h00);
  endtask

  task automatic t_gate();
    logic [7:0] s, d0, d1;
    prog(24'h000010, 8'h12, 8'h00, 1);
    rd_mem(24'h000010, d0, d1);
    check("R4 program ignored without latch", d0, 8'hFF);
    wr_status(8'hFC);
    rd_status(s);
    check("R4 status write ignored without latch", s, 8'h00);
  endtask

  task automatic t_program();
    logic [7:0] s, d0, d1;
    cmd1(8'h06);
    prog(24'h000105, 8'hA5, 8'h3C, 2);
    rd_status(s);
    check("R5 latch dropped after program", s, 8'h00);
    rd_mem(24'h000105, d0, d1);
    check("R6 read first byte", d0, 8'hA5);
    check("R6 read increments address", d1, 8'h3C);
    cmd1(8'h06);
    prog(24'h000105, 8'h0F, 8'h00, 1);
    rd_mem(24'h000105, d0, d1);
    check("R8 program ANDs into stored byte", d0, 8'h05);
    rd_mem(24'h020105, d0, d1);
    check("R6 index uses low address bits", d0, 8'h05);
    cmd1(8'h06);
    prog(24'h0001FF, 8'h11, 8'h22, 2);
    rd_mem(24'h0001FF, d0, d1);
    check("R8 last byte of page", d0, 8'h11);
    check("R6 read crosses page boundary", d1, 8'hFF);
    rd_mem(24'h000100, d0, d1);
    check("R8 program wraps within page", d0, 8'h22);
  endtask

  task automatic t_fast();
    logic [7:0] r, dm, d0, d1;
    frame_start();
    xfer(8'h0B, r);
    send_addr(24'h000105);
    xfer(8'h00, dm);
    xfer(8'hFF, d0);
    xfer(8'hFF, d1);
    frame_end();
    check("R14 dummy byte returns high", dm, 8'hFF);
    check("R7 fast read first byte", d0, 8'h05);
    check("R7 fast read second byte", d1, 8'h3C);
  endtask

  task automatic t_status_write();
    logic [7:0] s;
    cmd1(8'h06);
    wr_status(8'hFF);
    rd_status(s);
    check("R10 status bits 7:2 written, bit0 zero", s, 8'hFC);
    cmd1(8'h06);
    rd_status(s);
    check("R10 bit1 remains the latch", s, 8'hFE);
    wr_status(8'h00);
    rd_status(s);
    check("R5 latch dropped after status write", s, 8'h00);
  endtask

  task automatic t_erase();
    logic [7:0] s, d0, d1;
    cmd1(8'h06);
    sect_erase(24'h070000);
    rd_mem(24'h000105, d0, d1);
    check("R9 other sector leaves array", d0, 8'h05);
    rd_status(s);
    check("R5 latch dropped after sector erase", s, 8'h00);
    cmd1(8'h06);
    sect_erase(24'h000000);
    rd_mem(24'h000105, d0, d1);
    check("R9 sector erase clears byte", d0, 8'hFF);
    rd_mem(24'h000100, d0, d1);
    check("R9 sector erase clears page start", d0, 8'hFF);
    cmd1(8'h06);
    prog(24'h000020, 8'h5A, 8'h00, 1);
    cmd1(8'hC7);
    rd_mem(24'h000020, d0, d1);
    check("R4 bulk erase ignored without latch", d0, 8'h5A);
    cmd1(8'h06);
    cmd1(8'hC7);
    rd_mem(24'h000020, d0, d1);
    check("R9 bulk erase clears array", d0, 8'hFF);
  endtask

  task automatic t_signature();
    logic [7:0] r, d0, d1;
    frame_start();
    xfer(8'hAB, r);
    send_addr(24'h000000);
    xfer(8'hFF, d0);
    xfer(8'hFF, d1);
    frame_end();
    check("R11 signature byte", d0, 8'h13);
    check("R11 signature repeats", d1, 8'h13);
  endtask

  task automatic t_sleep();
    logic [7:0] r, s, d0;
    cmd1(8'hB9);
    rd_status(s);
    check("R12 status read ignored asleep", s, 8'hFF);
    cmd1(8'h06);
    frame_start();
    xfer(8'hAB, r);
    send_addr(24'h000000);
    xfer(8'hFF, d0);
    frame_end();
    check("R12 signature wakes device", d0, 8'h13);
    rd_status(s);
    check("R12 write enable ignored while asleep", s, 8'h00);
    cmd1(8'h06);
    rd_status(s);
    check("R12 opcodes accepted after wake", s, 8'h02);
    cmd1(8'h04);
  endtask

  task automatic t_abort();
    logic [7:0] r, s;
    frame_start();
    for (int i = 7; i >= 1; i--) begin
      mosi = 8'h06 >> i;
      tick(HALF);
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    mosi = 1'b0;
    tick(HALF);
    sclk = 1'b1;
    cs_n = 1'b1;
    tick(HALF);
    sclk = 1'b0;
    tick(10);
    rd_status(s);
    check("R13 byte ending with deselect is dropped", s, 8'h00);
    frame_start();
    xfer(8'h03, r);
    xfer(8'h00, r);
    frame_end();
    cmd1(8'h06);
    rd_status(s);
    check("R13 next transfer starts at opcode", s, 8'h02);
    cmd1(8'h04);
    check("R14 miso high after abort", {7'd0, miso}, 8'h01);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_latch();
    t_gate();
    t_program();
    t_fast();
    t_status_write();
    t_erase();
    t_signature();
    t_sleep();
    t_abort();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1-chain actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule